// File: doc/BRIEF.md
# Four-State Snooping Coherence Controller

This block keeps the coherence state of a small group of cache lines belonging to one cache that shares a snooping bus with peer caches. Each line is in one of four states: Modified (dirty, sole copy), Owned (dirty, while peers hold read copies), Shared (clean and current) or Invalid (unusable). Local processor reads, writes and evictions arrive on one port. Commands seen on the bus from peer caches arrive on a second port. The block works out the new state of each line, the bus command to issue for the local request, whether this cache must supply data for a snooped read, and whether an eviction needs a write-back to memory.

Memory is only updated on eviction, so a dirty line can stay dirty while it is shared. A snooped read of a Modified line moves it to Owned. An Owned line supplies data to later readers without a memory update. The data array, tag matching and bus arbitration are outside the block. A bus command driven here is taken as issued in the cycle it appears.

Top module: `mosi_snoop_ctrl`

## Requirements
- R1: After synchronous reset every line reads Invalid (code 0) on `line_state`, and `bus_valid`, `supply_valid`, `wb_valid` and `cpu_hit` are 0. State codes are I=0, S=1, O=2, M=3, with line k at bits [2k+1:2k].
- R2: A local read (op 0) on an Invalid line issues a bus read (cmd 1) and leaves the line Shared. A local read on a Shared, Owned or Modified line raises `cpu_hit`, issues no bus command and keeps the state.
- R3: A local write (op 1) on an Invalid line issues a read-for-ownership (cmd 2) and leaves the line Modified, without `cpu_hit`.
- R4: A local write on a Shared or Owned line issues an invalidate (cmd 3) and leaves the line Modified. A local write on a Modified line raises `cpu_hit` and issues nothing.
- R5: A snooped bus read (cmd 1) on a Modified line raises `supply_valid` and moves the line to Owned. On an Owned line it raises `supply_valid` and keeps Owned. On Shared or Invalid it changes nothing and supplies nothing.
- R6: A snooped read-for-ownership (cmd 2) moves any line to Invalid, and raises `supply_valid` only when the line was Modified or Owned. A snooped invalidate (cmd 3) moves any line to Invalid with no supply and no write-back.
- R7: A local eviction (op 2) of a Modified or Owned line raises `wb_valid` with the line index and leaves the line Invalid. Evicting a Shared line makes it Invalid with no bus command and no write-back. Evicting an Invalid line does nothing.
- R8: When a snoop and a local request name the same line in the same cycle, the snoop is applied first, and the local request acts on the state the snoop leaves.
- R9: A snoop and a local request on different lines in the same cycle each take full effect. All responses appear on the outputs one clock after the request and carry the request's line index.
- R10: A request with `cpu_valid` low or op 3, and a snoop with `snp_valid` low or cmd 0, change no line state and raise no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Local request present |
| cpu_op | input | 2 | Local request: 0 read, 1 write, 2 evict, 3 no-op |
| cpu_idx | input | IDX_W | Line addressed by the local request |
| snp_valid | input | 1 | Snooped command present |
| snp_cmd | input | 2 | Snooped command: 0 none, 1 read, 2 read-for-ownership, 3 invalidate |
| snp_idx | input | IDX_W | Line addressed by the snoop |
| bus_valid | output | 1 | Bus command issued for the local request |
| bus_cmd | output | 2 | Issued command, same coding as `snp_cmd` |
| bus_idx | output | IDX_W | Line of the issued command |
| supply_valid | output | 1 | This cache supplies data for the snooped command |
| supply_idx | output | IDX_W | Line being supplied |
| wb_valid | output | 1 | Write-back of a dirty line to memory |
| wb_idx | output | IDX_W | Line being written back |
| cpu_hit | output | 1 | Local request completed without bus traffic |
| line_state | output | 2*N_LINES | Current state of every line |

## Verification
The bench builds the block with N_LINES at its default of 4, so IDX_W is 2. Random line indices then land on the same line often, and snoops and local requests meet on one line in the same cycle many times per run. This covers the ordering rule of R8 and the back-and-forth between Owned, Modified and Invalid under load, beyond the directed sequence. Four lines also allow a snoop on one line and a local request on another to be paired in every combination of states.

// File: rtl/mosi_pkg.sv
package mosi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_O = 2'd2,
        ST_M = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_RD   = 2'd1,
        BC_RDX  = 2'd2,
        BC_UPG  = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2,
        OP_NOP   = 2'd3
    } cpu_op_e;

    typedef struct packed {
        bus_cmd_e cmd;
        logic     wb;
        logic     hit;
    } cpu_resp_t;

    function automatic logic is_dirty(line_st_e st);
        return (st == ST_M) || (st == ST_O);
    endfunction

    // state after a peer command is observed on the bus
    function automatic line_st_e snoop_next(line_st_e st, bus_cmd_e cmd);
        line_st_e r;
        r = st;
        case (cmd)
            BC_RD:          if (st == ST_M) r = ST_O;
            BC_RDX, BC_UPG: r = ST_I;
            default:        r = st;
        endcase
        return r;
    endfunction

    // this cache drives the line for a peer that needs the data
    function automatic logic snoop_supplies(line_st_e st, bus_cmd_e cmd);
        return is_dirty(st) && ((cmd == BC_RD) || (cmd == BC_RDX));
    endfunction

    function automatic line_st_e local_next(line_st_e st, cpu_op_e op);
        line_st_e r;
        case (op)
            OP_READ:  r = (st == ST_I) ? ST_S : st;
            OP_WRITE: r = ST_M;
            OP_EVICT: r = ST_I;
            default:  r = st;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mosi_line_fsm.sv
module mosi_line_fsm
    import mosi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cpu_sel,
    input  cpu_op_e  cpu_op,
    input  logic     snp_sel,
    input  bus_cmd_e snp_cmd,
    output line_st_e cur_st,
    output line_st_e mid_st
);

    line_st_e nxt_st;

    // snoop is resolved before the local request on the same line
    always_comb begin
        mid_st = snp_sel ? snoop_next(cur_st, snp_cmd) : cur_st;
        nxt_st = cpu_sel ? local_next(mid_st, cpu_op) : mid_st;
    end

    always_ff @(posedge clk) begin
        if (rst) cur_st <= ST_I;
        else     cur_st <= nxt_st;
    end

    // R3
    write_to_m_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_sel && cpu_op == OP_WRITE) |=> (cur_st == ST_M));

    // R7
    evict_to_i_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_sel && cpu_op == OP_EVICT) |=> (cur_st == ST_I));

    // R5
    snoop_rd_m_to_o_chk: assert property (@(posedge clk) disable iff (rst)
        (snp_sel && snp_cmd == BC_RD && cur_st == ST_M && !cpu_sel) |=> (cur_st == ST_O));

    // R6
    snoop_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (snp_sel && (snp_cmd == BC_UPG || snp_cmd == BC_RDX) && !cpu_sel) |=> (cur_st == ST_I));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_sel && !snp_sel) |=> $stable(cur_st));

endmodule

// File: rtl/mosi_req_decode.sv
module mosi_req_decode
    import mosi_pkg::*;
(
    input  logic      en,
    input  cpu_op_e   op,
    input  line_st_e  st,
    output cpu_resp_t resp
);

    always_comb begin
        resp = '{cmd: BC_NONE, wb: 1'b0, hit: 1'b0};
        if (en) begin
            case (op)
                OP_READ: begin
                    if (st == ST_I) resp.cmd = BC_RD;
                    else            resp.hit = 1'b1;
                end
                OP_WRITE: begin
                    case (st)
                        ST_I:       resp.cmd = BC_RDX;
                        ST_S, ST_O: resp.cmd = BC_UPG;
                        default:    resp.hit = 1'b1;
                    endcase
                end
                OP_EVICT: resp.wb = is_dirty(st);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mosi_snoop_ctrl.sv
module mosi_snoop_ctrl
    import mosi_pkg::*;
#(
    parameter int N_LINES = 4,
    localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cpu_valid,
    input  logic [1:0]             cpu_op,
    input  logic [IDX_W-1:0]       cpu_idx,
    input  logic                   snp_valid,
    input  logic [1:0]             snp_cmd,
    input  logic [IDX_W-1:0]       snp_idx,
    output logic                   bus_valid,
    output logic [1:0]             bus_cmd,
    output logic [IDX_W-1:0]       bus_idx,
    output logic                   supply_valid,
    output logic [IDX_W-1:0]       supply_idx,
    output logic                   wb_valid,
    output logic [IDX_W-1:0]       wb_idx,
    output logic                   cpu_hit,
    output logic [2*N_LINES-1:0]   line_state
);

    cpu_op_e   op_e;
    bus_cmd_e  snp_e;
    logic      cpu_act, snp_act;
    line_st_e  cur_v [N_LINES];
    line_st_e  mid_v [N_LINES];
    line_st_e  cpu_mid_sel, snp_cur_sel;
    cpu_resp_t resp;
    logic      supply_nxt;

    assign op_e    = cpu_op_e'(cpu_op);
    assign snp_e   = bus_cmd_e'(snp_cmd);
    assign cpu_act = cpu_valid && (op_e != OP_NOP) && (int'(cpu_idx) < N_LINES);
    assign snp_act = snp_valid && (snp_e != BC_NONE) && (int'(snp_idx) < N_LINES);

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        mosi_line_fsm u_line (
            .clk     (clk),
            .rst     (rst),
            .cpu_sel (cpu_act && (int'(cpu_idx) == g)),
            .cpu_op  (op_e),
            .snp_sel (snp_act && (int'(snp_idx) == g)),
            .snp_cmd (snp_e),
            .cur_st  (cur_v[g]),
            .mid_st  (mid_v[g])
        );
        assign line_state[2*g +: 2] = cur_v[g];
    end

    always_comb begin
        cpu_mid_sel = ST_I;
        snp_cur_sel = ST_I;
        for (int k = 0; k < N_LINES; k++) begin
            if (int'(cpu_idx) == k) cpu_mid_sel = mid_v[k];
            if (int'(snp_idx) == k) snp_cur_sel = cur_v[k];
        end
    end

    mosi_req_decode u_dec (
        .en   (cpu_act),
        .op   (op_e),
        .st   (cpu_mid_sel),
        .resp (resp)
    );

    assign supply_nxt = snp_act && snoop_supplies(snp_cur_sel, snp_e);

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_valid    <= 1'b0;
            bus_cmd      <= BC_NONE;
            bus_idx      <= '0;
            supply_valid <= 1'b0;
            supply_idx   <= '0;
            wb_valid     <= 1'b0;
            wb_idx       <= '0;
            cpu_hit      <= 1'b0;
        end else begin
            bus_valid    <= (resp.cmd != BC_NONE);
            bus_cmd      <= resp.cmd;
            bus_idx      <= cpu_idx;
            supply_valid <= supply_nxt;
            supply_idx   <= snp_idx;
            wb_valid     <= resp.wb;
            wb_idx       <= cpu_idx;
            cpu_hit      <= resp.hit;
        end
    end

    // R2
    rd_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_act && op_e == OP_READ && cpu_mid_sel == ST_I) |=> (bus_valid && bus_cmd == BC_RD));

    // R7
    wb_quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (!bus_valid && !cpu_hit));

    // R6
    upg_no_supply_chk: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_e == BC_UPG) |=> !supply_valid);

    // R4
    hit_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_hit |-> !bus_valid);

endmodule

// File: tb/mosi_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module mosi_snoop_ctrl_tb;

    localparam int N  = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_valid = 1'b0;
    logic [1:0]    cpu_op = 2'd3;
    logic [IW-1:0] cpu_idx = '0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = 2'd0;
    logic [IW-1:0] snp_idx = '0;
    logic          bus_valid, supply_valid, wb_valid, cpu_hit;
    logic [1:0]    bus_cmd;
    logic [IW-1:0] bus_idx, supply_idx, wb_idx;
    logic [2*N-1:0] line_state;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int mst [N];   // model: 0 I, 1 S, 2 O, 3 M

    always #2.5 clk = ~clk;

    mosi_snoop_ctrl #(.N_LINES(N)) u_dut (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_idx(cpu_idx),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_idx(snp_idx),
        .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_idx(bus_idx),
        .supply_valid(supply_valid), .supply_idx(supply_idx),
        .wb_valid(wb_valid), .wb_idx(wb_idx),
        .cpu_hit(cpu_hit), .line_state(line_state)
    );

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // one clock: drive at negedge, compare at the following negedge
    task automatic step(string tag, bit cv, int op, int ci, bit sv, int sc, int si);
        int mid [N];
        int e_bv, e_bc, e_sv, e_wv, e_hit, s;
        e_bv = 0; e_bc = 0; e_sv = 0; e_wv = 0; e_hit = 0;
        for (int k = 0; k < N; k++) mid[k] = mst[k];
        if (sv && sc != 0) begin
            s = mst[si];
            if ((s == 3 || s == 2) && (sc == 1 || sc == 2)) e_sv = 1;
            if (sc == 1 && s == 3) mid[si] = 2;
            if (sc == 2 || sc == 3) mid[si] = 0;
        end
        if (cv && op != 3) begin
            s = mid[ci];
            if (op == 0) begin
                if (s == 0) begin e_bv = 1; e_bc = 1; mid[ci] = 1; end
                else e_hit = 1;
            end else if (op == 1) begin
                if (s == 0) begin e_bv = 1; e_bc = 2; end
                else if (s == 3) e_hit = 1;
                else begin e_bv = 1; e_bc = 3; end
                mid[ci] = 3;
            end else begin
                if (s == 2 || s == 3) e_wv = 1;
                mid[ci] = 0;
            end
        end
        cpu_valid = cv; cpu_op = 2'(op); cpu_idx = IW'(ci);
        snp_valid = sv; snp_cmd = 2'(sc); snp_idx = IW'(si);
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < N; k++) mst[k] = mid[k];
        chk(tag, "bus_valid", int'(bus_valid), e_bv);
        if (e_bv) begin
            chk(tag, "bus_cmd", int'(bus_cmd), e_bc);
            chk(tag, "bus_idx", int'(bus_idx), ci);
        end
        chk(tag, "supply_valid", int'(supply_valid), e_sv);
        if (e_sv) chk(tag, "supply_idx", int'(supply_idx), si);
        chk(tag, "wb_valid", int'(wb_valid), e_wv);
        if (e_wv) chk(tag, "wb_idx", int'(wb_idx), ci);
        chk(tag, "cpu_hit", int'(cpu_hit), e_hit);
        for (int k = 0; k < N; k++) chk(tag, "line_state", int'(line_state[2*k +: 2]), mst[k]);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            finish_run();
        end
    end

    initial begin
        for (int k = 0; k < N; k++) mst[k] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "line_state", int'(line_state), 0);
        chk("R1", "bus_valid", int'(bus_valid), 0);
        chk("R1", "supply_valid", int'(supply_valid), 0);
        chk("R1", "wb_valid", int'(wb_valid), 0);
        chk("R1", "cpu_hit", int'(cpu_hit), 0);

        step("R2", 1, 0, 0, 0, 0, 0);   // read miss line0 -> S
        step("R2", 1, 0, 0, 0, 0, 0);   // read hit in S
        step("R3", 1, 1, 1, 0, 0, 0);   // write miss line1 -> M
        step("R4", 1, 1, 1, 0, 0, 0);   // write hit in M
        step("R4", 1, 1, 0, 0, 0, 0);   // write in S -> invalidate, M
        step("R5", 0, 0, 0, 1, 1, 0);   // snoop read M -> O, supply
        step("R5", 0, 0, 0, 1, 1, 0);   // snoop read O stays, supply
        step("R5", 0, 0, 0, 1, 1, 2);   // snoop read on I, nothing
        step("R2", 1, 0, 0, 0, 0, 0);   // read hit in O
        step("R4", 1, 1, 0, 0, 0, 0);   // write in O -> invalidate, M
        step("R6", 0, 0, 0, 1, 2, 0);   // snoop rfo on M -> I, supply
        step("R2", 1, 0, 2, 0, 0, 0);   // line2 -> S
        step("R5", 0, 0, 0, 1, 1, 2);   // snoop read on S, nothing
        step("R6", 0, 0, 0, 1, 3, 2);   // snoop invalidate S -> I
        step("R3", 1, 1, 3, 0, 0, 0);   // line3 -> M
        step("R5", 0, 0, 0, 1, 1, 3);   // line3 -> O
        step("R7", 1, 2, 3, 0, 0, 0);   // evict O -> write-back
        step("R2", 1, 0, 2, 0, 0, 0);   // line2 -> S
        step("R7", 1, 2, 2, 0, 0, 0);   // evict S, quiet
        step("R7", 1, 2, 2, 0, 0, 0);   // evict I, nothing
        step("R3", 1, 1, 3, 0, 0, 0);   // line3 -> M
        step("R7", 1, 2, 3, 0, 0, 0);   // evict M -> write-back
        step("R8", 1, 1, 1, 1, 3, 1);   // inv + write same line: rfo
        step("R8", 1, 2, 1, 1, 1, 1);   // read snoop + evict: supply and wb
        step("R3", 1, 1, 1, 0, 0, 0);   // line1 -> M again
        step("R9", 1, 0, 0, 1, 1, 1);   // different lines same cycle
        step("R6", 0, 0, 0, 1, 2, 2);   // snoop rfo on I, nothing
        step("R10", 1, 3, 1, 1, 0, 1);  // no-op and empty snoop
        step("R10", 0, 1, 1, 0, 3, 1);  // valids low
        step("R10", 0, 2, 0, 0, 2, 0);

        for (int i = 0; i < 3000; i++) begin
            step("R9", ($urandom_range(0, 3) != 0), $urandom_range(0, 3), $urandom_range(0, N - 1),
                 ($urandom_range(0, 2) != 0), $urandom_range(0, 3), $urandom_range(0, N - 1));
        end

        done = 1;
        finish_run();
    end

endmodule